// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Converter Front End

This block is the digital side of a 16-bit converter that is fed from an 8-bit parallel bus. It holds two 16-bit registers. The staging register is filled one byte at a time, and the output register drives the converter code. A byte write is an active-low strobe whose falling edge stores the bus byte into the half named by a byte-select line. That selection is frozen at the edge. An active-low load level copies the staging register into the output register, and each falling edge of load starts a one-clock deglitch pulse. Several devices can share one load line, so their outputs change in the same cycle.

Write and load are sampled into the system clock through multi-flop synchronizers. A clear input is asynchronous and active low. It forces both registers to zero scale (0x0000) or to midscale (0x8000), as chosen by a clear-level pin. A separate power-on reset puts the whole block into a known state with both registers at zero.

Top module: `dac_byte_front`

## Requirements
- R1: While `rstN` is low and after it is released, `dacCode` is 0x0000, the staging register is 0x0000 and `deglitch` is low.
- R2: A falling edge of `wrN` with `byteSel` = 0 stores `busByte` into bits 7:0 of the staging register and leaves bits 15:8 unchanged.
- R3: A falling edge of `wrN` with `byteSel` = 1 stores `busByte` into bits 15:8 of the staging register and leaves bits 7:0 unchanged.
- R4: `byteSel` and `busByte` take effect only at the falling edge of `wrN`. Changes to them while `wrN` stays low store nothing further.
- R5: `dacCode` keeps its value while `ldN` is high, whatever is written to the staging register.
- R6: While `ldN` is low, `dacCode` takes the staging register value. The first copy appears on the third rising clock edge after `ldN` falls.
- R7: Each falling edge of `ldN` gives exactly one `deglitch` pulse, one clock wide, which is high after the third rising edge following the fall.
- R8: `clrN` low with `clrLevel` = 0 sets `dacCode` and the staging register to 0x0000 at once, without a clock edge.
- R9: `clrN` low with `clrLevel` = 1 sets `dacCode` and the staging register to 0x8000 at once, without a clock edge.
- R10: While `clrN` is low, write edges and load levels leave both registers at the clear value.
- R11: A write edge while `ldN` is held low reaches `dacCode` one clock after it reaches the staging register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| busByte | input | 8 | Parallel data byte |
| byteSel | input | 1 | Half select: 0 low byte, 1 high byte |
| wrN | input | 1 | Byte write strobe, active on falling edge |
| ldN | input | 1 | Load level, active low |
| clrN | input | 1 | Clear, active low, asynchronous |
| clrLevel | input | 1 | Clear value: 0 zero scale, 1 midscale |
| dacCode | output | 16 | Converter code from the output register |
| deglitch | output | 1 | One-clock pulse per load falling edge |

## Verification
Directed byte writes put distinct patterns into each half, and each half is then checked on its own through a load. This separates a swapped or merged lane from a correct one. One write changes the select and the bus byte while `wrN` is still low, which exposes any capture on the level rather than the edge. Load and write timing is checked cycle by cycle, both with load pulsed and with load held low. Clears are applied between clock edges at both clear levels, and a later load then shows that the staging register was cleared as well.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  // Strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic loadDac;
  } dacStrobes_t;
endpackage

// File: rtl/dacfe_ctrl.sv
module dacfe_ctrl
  import dacfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrN,
  input  logic        ldN,
  input  logic        byteSel,
  output dacStrobes_t strb,
  output logic        deglitch
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] wrSync;
  logic [SYNC_STAGES-1:0] ldSync;
  logic wrPrev;
  logic ldPrev;
  logic wrFall;
  logic ldFall;

  // synchronizer chains, idle level high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrSync[g] <= 1'b1;
        ldSync[g] <= 1'b1;
      end else if (g == 0) begin
        wrSync[g] <= wrN;
        ldSync[g] <= ldN;
      end else begin
        wrSync[g] <= wrSync[(g == 0) ? 0 : g-1];
        ldSync[g] <= ldSync[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev   <= 1'b1;
      ldPrev   <= 1'b1;
      deglitch <= 1'b0;
    end else begin
      wrPrev   <= wrSync[LAST];
      ldPrev   <= ldSync[LAST];
      deglitch <= ldFall;
    end
  end

  assign wrFall = wrPrev & ~wrSync[LAST];
  assign ldFall = ldPrev & ~ldSync[LAST];

  always_comb begin
    strb.loadLo  = wrFall & ~byteSel;
    strb.loadHi  = wrFall & byteSel;
    strb.loadDac = ~ldSync[LAST];
  end

  // R7
  deglitch_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    deglitch |=> !deglitch);

  // R4
  single_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadLo || strb.loadHi) |=> !(strb.loadLo || strb.loadHi));

  // R2
  lane_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadLo, strb.loadHi}));
endmodule

// File: rtl/dacfe_data.sv
module dacfe_data
  import dacfe_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clrN,
  input  logic                clrLevel,
  input  logic [BYTE_W-1:0]   busByte,
  input  dacStrobes_t         strb,
  output logic [2*BYTE_W-1:0] dacCode
);
  localparam int LANES = 2;
  localparam int REG_W = LANES * BYTE_W;
  localparam logic [REG_W-1:0] MID_SCALE = {1'b1, {(REG_W-1){1'b0}}};

  logic [REG_W-1:0] clrVal;
  logic [REG_W-1:0] stageReg;
  logic [REG_W-1:0] outReg;
  logic [LANES-1:0] laneLoad;

  assign clrVal   = clrLevel ? MID_SCALE : '0;
  assign laneLoad = {strb.loadHi, strb.loadLo};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rstN or negedge clrN) begin
      if (!rstN)
        stageReg[l*BYTE_W +: BYTE_W] <= '0;
      else if (!clrN)
        stageReg[l*BYTE_W +: BYTE_W] <= clrVal[l*BYTE_W +: BYTE_W];
      else if (laneLoad[l])
        stageReg[l*BYTE_W +: BYTE_W] <= busByte;
    end
  end

  always_ff @(posedge clk or negedge rstN or negedge clrN) begin
    if (!rstN)
      outReg <= '0;
    else if (!clrN)
      outReg <= clrVal;
    else if (strb.loadDac)
      outReg <= stageReg;
  end

  assign dacCode = outReg;

  // R2
  low_lane_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    strb.loadLo |=> (stageReg[BYTE_W-1:0] == $past(busByte)) &&
                    (stageReg[REG_W-1:BYTE_W] == $past(stageReg[REG_W-1:BYTE_W])));

  // R3
  high_lane_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    strb.loadHi |=> (stageReg[REG_W-1:BYTE_W] == $past(busByte)) &&
                    (stageReg[BYTE_W-1:0] == $past(stageReg[BYTE_W-1:0])));

  // R6
  dac_follow_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    strb.loadDac |=> outReg == $past(stageReg));

  // R5
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !strb.loadDac |=> $stable(outReg));

  // R10
  clear_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> (outReg == (clrLevel ? MID_SCALE : '0)) && (stageReg == outReg));
endmodule

// File: rtl/dac_byte_front.sv
module dac_byte_front
  import dacfe_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   busByte,
  input  logic                byteSel,
  input  logic                wrN,
  input  logic                ldN,
  input  logic                clrN,
  input  logic                clrLevel,
  output logic [2*BYTE_W-1:0] dacCode,
  output logic                deglitch
);
  dacStrobes_t strb;

  dacfe_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrN      (wrN),
    .ldN      (ldN),
    .byteSel  (byteSel),
    .strb     (strb),
    .deglitch (deglitch)
  );

  dacfe_data #(.BYTE_W(BYTE_W)) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .clrN     (clrN),
    .clrLevel (clrLevel),
    .busByte  (busByte),
    .strb     (strb),
    .dacCode  (dacCode)
  );
endmodule

// File: tb/test_dac_byte_front.sv
module test_dac_byte_front;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  busByte;
  logic        byteSel;
  logic        wrN;
  logic        ldN;
  logic        clrN;
  logic        clrLevel;
  logic [15:0] dacCode;
  logic        deglitch;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_byte_front i_dac_byte_front (
    .clk(clk), .rstN(rstN), .busByte(busByte), .byteSel(byteSel),
    .wrN(wrN), .ldN(ldN), .clrN(clrN), .clrLevel(clrLevel),
    .dacCode(dacCode), .deglitch(deglitch)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeByte(input logic sel, input logic [7:0] b);
    byteSel = sel; busByte = b; wrN = 1'b0;
    waitNeg(4);
    wrN = 1'b1;
    waitNeg(3);
  endtask

  task automatic pulseLoad();
    ldN = 1'b0;
    waitNeg(4);
    ldN = 1'b1;
    waitNeg(3);
  endtask

  task automatic t_reset();
    rstN = 1'b0; busByte = '0; byteSel = 1'b0; wrN = 1'b1; ldN = 1'b1;
    clrN = 1'b1; clrLevel = 1'b0;
    waitNeg(3);
    chk("R1 code in reset", dacCode, 16'h0000);
    rstN = 1'b1;
    waitNeg(2);
    chk("R1 code after reset", dacCode, 16'h0000);
    chk("R1 deglitch after reset", {15'b0, deglitch}, 16'h0000);
    pulseLoad();
    chk("R1 staging register after reset", dacCode, 16'h0000);
  endtask

  task automatic t_lowByte();
    writeByte(1'b0, 8'h3C);
    chk("R5 code held without load", dacCode, 16'h0000);
    pulseLoad();
    chk("R2 low byte", dacCode, 16'h003C);
  endtask

  task automatic t_highByte();
    writeByte(1'b1, 8'hA5);
    chk("R5 code held without load", dacCode, 16'h003C);
    pulseLoad();
    chk("R3 high byte", dacCode, 16'hA53C);
  endtask

  task automatic t_selFrozen();
    byteSel = 1'b0; busByte = 8'h11; wrN = 1'b0;
    waitNeg(4);
    byteSel = 1'b1; busByte = 8'h77;
    waitNeg(4);
    wrN = 1'b1;
    waitNeg(3);
    pulseLoad();
    chk("R4 select frozen at write edge", dacCode, 16'hA511);
  endtask

  task automatic t_loadTiming();
    writeByte(1'b0, 8'h22);
    ldN = 1'b0;
    waitNeg(1);
    chk("R7 no pulse after edge 1", {15'b0, deglitch}, 16'h0);
    chk("R6 code old after edge 1", dacCode, 16'hA511);
    waitNeg(1);
    chk("R7 no pulse after edge 2", {15'b0, deglitch}, 16'h0);
    chk("R6 code old after edge 2", dacCode, 16'hA511);
    waitNeg(1);
    chk("R7 pulse after edge 3", {15'b0, deglitch}, 16'h1);
    chk("R6 code new after edge 3", dacCode, 16'hA522);
    waitNeg(1);
    chk("R7 pulse one clock wide", {15'b0, deglitch}, 16'h0);
  endtask

  task automatic t_writeDuringLoad();
    byteSel = 1'b1; busByte = 8'h5A; wrN = 1'b0;
    waitNeg(3);
    chk("R11 code not yet updated", dacCode, 16'hA522);
    waitNeg(1);
    chk("R11 code updated one clock later", dacCode, 16'h5A22);
    wrN = 1'b1;
    waitNeg(3);
    ldN = 1'b1;
    waitNeg(3);
    chk("R7 no pulse on load rise", {15'b0, deglitch}, 16'h0);
  endtask

  task automatic t_clearZero();
    clrLevel = 1'b0;
    #2 clrN = 1'b0;
    #1 chk("R8 async clear to zero", dacCode, 16'h0000);
    waitNeg(2);
    clrN = 1'b1;
    waitNeg(2);
    pulseLoad();
    chk("R8 staging cleared to zero", dacCode, 16'h0000);
  endtask

  task automatic t_clearMid();
    writeByte(1'b0, 8'h01);
    writeByte(1'b1, 8'h02);
    pulseLoad();
    chk("R2 R3 both bytes", dacCode, 16'h0201);
    clrLevel = 1'b1;
    #2 clrN = 1'b0;
    #1 chk("R9 async clear to midscale", dacCode, 16'h8000);
    waitNeg(2);
    clrN = 1'b1;
    waitNeg(2);
    pulseLoad();
    chk("R9 staging cleared to midscale", dacCode, 16'h8000);
  endtask

  task automatic t_clearPriority();
    clrLevel = 1'b1;
    clrN = 1'b0;
    waitNeg(1);
    byteSel = 1'b0; busByte = 8'hEE; wrN = 1'b0; ldN = 1'b0;
    waitNeg(5);
    chk("R10 clear beats write and load", dacCode, 16'h8000);
    wrN = 1'b1;
    waitNeg(3);
    clrN = 1'b1;
    waitNeg(4);
    chk("R10 write during clear not kept", dacCode, 16'h8000);
    ldN = 1'b1;
    waitNeg(3);
  endtask

  initial begin
    t_reset();
    t_lowByte();
    t_highByte();
    t_selFrozen();
    t_loadTiming();
    t_writeDuringLoad();
    t_clearZero();
    t_clearMid();
    t_clearPriority();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule